// File: doc/BRIEF.md
# Signed-Amount Operand Shifter with Accumulating Result

This block shifts a 16-bit operand within a 32-bit field in a single cycle and leaves the result in a registered 32-bit result register (SR). The operand is first placed in the upper or the lower half of the field. It is then moved left or right by a signed 8-bit amount, in arithmetic or logical mode. A positive amount moves it left and a negative amount moves it right.

The new field can replace SR, or it can be bitwise ORed into the value SR already holds. The operand can come from the input port, or it can be the current low half of SR fed back. With these options, software can build a full 32-bit shift from two operations that use the same amount. The first operation shifts the upper word arithmetically with the HI placement. The second shifts the lower word logically with the LO placement and the OR option, so the lower word's top bit is never sign-extended. The block raises no status flags.

Top module: `shift_accum_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears SR to 0x00000000, even when valid_i is high in the same cycle.
- R2: When valid_i is low at a rising edge, SR keeps its value, whatever the other inputs are.
- R3: Placement: with hi_sel_i=1 the operand occupies field bits 31:16 (bits 15:0 zero) before shifting; with hi_sel_i=0 it occupies bits 15:0.
- R4: A positive amount_i (two's complement, 1..127) shifts the field left. Vacated low bits are zero and bits moved past bit 31 are lost.
- R5: A negative amount_i shifts the field right by its magnitude and discards bits moved below bit 0. Vacated high bits are copies of the operand's MSB when arith_i=1, and zero when arith_i=0.
- R6: With hi_sel_i=0 and arith_i=1, field bits 31:16 are copies of operand bit 15 before shifting. With arith_i=0 they are zero.
- R7: For magnitudes of 32 or more (up to 128 for amount -128): a left shift gives zero, a logical right shift gives zero, and an arithmetic right shift gives 32 copies of the field's sign bit.
- R8: With merge_i=1 the new SR is the old SR bitwise ORed with the shifted field. With merge_i=0 the shifted field replaces SR.
- R9: With use_fb_i=1 the operand is SR bits 15:0 as they were before the edge that performs the update.
- R10: An arithmetic HI shift of the upper word, followed by a logical LO merge shift of the lower word with the same amount, leaves SR equal to the 32-bit value shifted arithmetically by that amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Perform an operation at this edge |
| operand_i | input | 16 | Operand from outside |
| amount_i | input | 8 | Signed shift amount, positive = left |
| arith_i | input | 1 | 1 = arithmetic mode, 0 = logical mode |
| hi_sel_i | input | 1 | 1 = place operand in bits 31:16, 0 = bits 15:0 |
| merge_i | input | 1 | 1 = OR result into SR, 0 = overwrite SR |
| use_fb_i | input | 1 | 1 = operand is SR bits 15:0 |
| result_o | output | 32 | Registered SR contents |

## Verification
The bench targets amounts at the edges of the range: -128, 127, and magnitudes just past 31. A shifter that wrapped the amount modulo 32 would return the operand instead of zero or sign fill at these amounts. Negative operands in the LO placement expose a missing sign extension into bits 31:16 in arithmetic mode, and also expose sign extension leaking into logical mode. The two-cycle 32-bit shift and the SR0 feedback case catch an OR that drops old bits and a feedback path that samples the value being written instead of the value SR held before the edge. A hold cycle with valid low catches SR updates that should not happen.

// File: rtl/shift_accum_pkg.sv
package shift_accum_pkg;
  localparam int OPERAND_W = 16;
  localparam int AMOUNT_W  = 8;

  typedef enum logic {
    SHIFT_LOGICAL = 1'b0,
    SHIFT_ARITH   = 1'b1
  } shift_mode_e;

  // Unsigned magnitude of a two's complement amount; the most negative value maps to 2**(W-1).
  function automatic logic [AMOUNT_W-1:0] amount_mag(input logic [AMOUNT_W-1:0] amt);
    return amt[AMOUNT_W-1] ? (~amt + 1'b1) : amt;
  endfunction

  // Place an operand in the upper or lower half of a double-width field.
  function automatic logic [2*OPERAND_W-1:0] place_operand(
    input logic [OPERAND_W-1:0] op, input logic hi, input shift_mode_e mode);
    logic [OPERAND_W-1:0] ext;
    ext = (mode == SHIFT_ARITH) ? {OPERAND_W{op[OPERAND_W-1]}} : '0;
    return hi ? {op, {OPERAND_W{1'b0}}} : {ext, op};
  endfunction
endpackage

// File: rtl/shift_place.sv
module shift_place
  import shift_accum_pkg::*;
#(
  parameter int OP_W = OPERAND_W,
  localparam int RES_W = 2 * OP_W
) (
  input  logic [OP_W-1:0]  operand,
  input  logic [RES_W-1:0] sr_now,
  input  logic             use_fb,
  input  logic             hi_sel,
  input  shift_mode_e      mode,
  output logic [OP_W-1:0]  op_sel,
  output logic [RES_W-1:0] field
);
  always_comb begin
    op_sel = use_fb ? sr_now[OP_W-1:0] : operand;
    field  = place_operand(op_sel, hi_sel, mode);
  end
endmodule

// File: rtl/shift_barrel.sv
module shift_barrel
  import shift_accum_pkg::*;
#(
  parameter int RES_W = 2 * OPERAND_W,
  parameter int AMT_W = AMOUNT_W,
  localparam int STG = $clog2(RES_W)
) (
  input  logic [RES_W-1:0] field,
  input  logic [AMT_W-1:0] amount,
  input  shift_mode_e      mode,
  output logic [RES_W-1:0] shifted,
  output logic             overrange
);
  logic [AMT_W-1:0] mag;
  logic             go_right;
  logic             fill;
  logic [RES_W-1:0] lft [STG+1];
  logic [RES_W-1:0] rgt [STG+1];

  assign mag       = amount_mag(amount);
  assign go_right  = amount[AMT_W-1];
  assign fill      = (mode == SHIFT_ARITH) & field[RES_W-1];
  assign overrange = |mag[AMT_W-1:STG];
  assign lft[0]    = field;
  assign rgt[0]    = field;

  for (genvar i = 0; i < STG; i++) begin : g_stage
    localparam int D = 1 << i;
    assign lft[i+1] = mag[i] ? {lft[i][RES_W-1-D:0], {D{1'b0}}} : lft[i];
    assign rgt[i+1] = mag[i] ? {{D{fill}}, rgt[i][RES_W-1:D]} : rgt[i];
  end

  always_comb begin
    if (go_right) shifted = overrange ? {RES_W{fill}} : rgt[STG];
    else          shifted = overrange ? '0 : lft[STG];
  end
endmodule

// File: rtl/shift_result_reg.sv
module shift_result_reg #(
  parameter int RES_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             merge,
  input  logic [RES_W-1:0] shifted,
  output logic [RES_W-1:0] next_sr,
  output logic [RES_W-1:0] sr
);
  assign next_sr = merge ? (sr | shifted) : shifted;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (valid) sr <= next_sr;
  end
endmodule

// File: rtl/shift_accum_unit.sv
module shift_accum_unit
  import shift_accum_pkg::*;
#(
  parameter int OP_W  = OPERAND_W,
  parameter int AMT_W = AMOUNT_W,
  localparam int RES_W = 2 * OP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  operand_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic             arith_i,
  input  logic             hi_sel_i,
  input  logic             merge_i,
  input  logic             use_fb_i,
  output logic [RES_W-1:0] result_o
);
  shift_mode_e      mode;
  logic [OP_W-1:0]  op_sel;
  logic [RES_W-1:0] placed_field;
  logic [RES_W-1:0] shifted_field;
  logic [RES_W-1:0] next_sr;
  logic             overrange;

  assign mode = arith_i ? SHIFT_ARITH : SHIFT_LOGICAL;

  shift_place #(.OP_W(OP_W)) u_place (
    .operand(operand_i), .sr_now(result_o), .use_fb(use_fb_i),
    .hi_sel(hi_sel_i), .mode(mode), .op_sel(op_sel), .field(placed_field)
  );

  shift_barrel #(.RES_W(RES_W), .AMT_W(AMT_W)) u_barrel (
    .field(placed_field), .amount(amount_i), .mode(mode),
    .shifted(shifted_field), .overrange(overrange)
  );

  shift_result_reg #(.RES_W(RES_W)) u_sr (
    .clk(clk), .rst(rst), .valid(valid_i), .merge(merge_i),
    .shifted(shifted_field), .next_sr(next_sr), .sr(result_o)
  );
endmodule

// File: rtl/shift_accum_checker.sv
module shift_accum_checker #(
  parameter int OP_W  = 16,
  parameter int AMT_W = 8,
  localparam int RES_W = 2 * OP_W
) (
  input logic             clk,
  input logic             rst,
  input logic             valid_i,
  input logic [OP_W-1:0]  operand_i,
  input logic [AMT_W-1:0] amount_i,
  input logic             arith_i,
  input logic             hi_sel_i,
  input logic             merge_i,
  input logic             use_fb_i,
  input logic             overrange,
  input logic [RES_W-1:0] result_o
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> result_o == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(result_o));

  p_merge_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    valid_i && merge_i |=> (result_o & $past(result_o)) == $past(result_o));

  p_far_left_zero_r7: assert property (@(posedge clk) disable iff (rst)
    valid_i && !merge_i && !amount_i[AMT_W-1] && overrange |=> result_o == '0);

  p_lo_logical_r6: assert property (@(posedge clk) disable iff (rst)
    valid_i && !merge_i && !use_fb_i && !arith_i && !hi_sel_i && amount_i == '0
    |=> result_o == {{OP_W{1'b0}}, $past(operand_i)});

  p_hi_low_clear_r3: assert property (@(posedge clk) disable iff (rst)
    valid_i && !merge_i && hi_sel_i && !amount_i[AMT_W-1] |=> result_o[OP_W-1:0] == '0);
endmodule

bind shift_accum_unit shift_accum_checker #(.OP_W(OP_W), .AMT_W(AMT_W)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .operand_i(operand_i),
  .amount_i(amount_i), .arith_i(arith_i), .hi_sel_i(hi_sel_i),
  .merge_i(merge_i), .use_fb_i(use_fb_i), .overrange(overrange),
  .result_o(result_o)
);

// File: tb/shift_accum_unit_test.sv
module shift_accum_unit_test;
  logic        clk = 1'b0;
  logic        rst, valid_i, arith_i, hi_sel_i, merge_i, use_fb_i;
  logic [15:0] operand_i;
  logic [7:0]  amount_i;
  logic [31:0] result_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  shift_accum_unit uut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .operand_i(operand_i),
    .amount_i(amount_i), .arith_i(arith_i), .hi_sel_i(hi_sel_i),
    .merge_i(merge_i), .use_fb_i(use_fb_i), .result_o(result_o)
  );

  localparam int NV = 14;
  localparam logic [15:0] T_OP  [NV] = '{16'h1234, 16'h1234, 16'h8001, 16'h8001, 16'h8001,
    16'h8001, 16'h8001, 16'h00FF, 16'h8000, 16'h8000, 16'h7FFF, 16'h7FFF, 16'h0001, 16'hC000};
  localparam logic [7:0]  T_AMT [NV] = '{8'd0, 8'd0, 8'd0, 8'd0, 8'd4, 8'hFC, 8'hFC, 8'd12,
    8'h80, 8'hD8, 8'h7F, 8'hD8, 8'd31, 8'hFF};
  localparam logic        T_AR  [NV] = '{0, 1, 1, 0, 1, 1, 0, 0, 1, 0, 1, 1, 0, 1};
  localparam logic        T_HI  [NV] = '{0, 1, 0, 0, 0, 1, 1, 1, 1, 1, 0, 0, 0, 1};
  localparam logic [31:0] T_EXP [NV] = '{32'h00001234, 32'h12340000, 32'hFFFF8001,
    32'h00008001, 32'hFFF80010, 32'hF8001000, 32'h08001000, 32'hF0000000, 32'hFFFFFFFF,
    32'h00000000, 32'h00000000, 32'h00000000, 32'h80000000, 32'hE0000000};
  localparam logic [15:0] T_TAG [NV] = '{"R3", "R3", "R6", "R6", "R4", "R5", "R5", "R4",
    "R7", "R7", "R7", "R7", "R4", "R5"};

  task automatic check(input string tag, input logic [31:0] exp);
    checks++;
    if (result_o !== exp) begin
      errors++;
      $display("FAIL %s: result %h expected %h", tag, result_o, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge act, come back to a falling edge.
  task automatic op(input logic [15:0] o, input logic [7:0] a, input logic ar,
                    input logic hi, input logic mg, input logic fb);
    operand_i = o; amount_i = a; arith_i = ar; hi_sel_i = hi;
    merge_i = mg; use_fb_i = fb; valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: result %h expected completion", result_o);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; valid_i = 1'b0; operand_i = '0; amount_i = '0;
    arith_i = 1'b0; hi_sel_i = 1'b0; merge_i = 1'b0; use_fb_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", 32'h0);

    for (int i = 0; i < NV; i++) begin
      op(T_OP[i], T_AMT[i], T_AR[i], T_HI[i], 1'b0, 1'b0);
      check($sformatf("%s vector %0d", T_TAG[i], i), T_EXP[i]);
    end

    // R2: valid low leaves SR alone
    op(16'hABCD, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    operand_i = 16'h5555; amount_i = 8'd3; hi_sel_i = 1'b1; arith_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 hold with valid low", 32'h0000ABCD);

    // R8: merge versus overwrite
    op(16'hF000, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    op(16'h000F, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R8 merge ORs into SR", 32'h0000F00F);
    op(16'h0001, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 overwrite replaces SR", 32'h00000001);

    // R9: SR0 fed back, sampled before the update
    op(16'h1234, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    op(16'h0000, 8'd3, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R9 feedback of SR0 merged", 32'h000093B4);

    // R10: two-cycle 32-bit shifts
    op(16'hC003, 8'hFC, 1'b1, 1'b1, 1'b0, 1'b0);
    op(16'h5678, 8'hFC, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R10 32-bit right by 4", 32'hFC003567);
    op(16'h1234, 8'd4, 1'b1, 1'b1, 1'b0, 1'b0);
    op(16'h5678, 8'd4, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R10 32-bit left by 4", 32'h23456780);

    // R7: logical right by the full -128 magnitude
    op(16'hFFFF, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R7 logical right -128", 32'h0);

    // R1: reset wins over a valid operation
    op(16'h00FF, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b1;
    op(16'h7777, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    check("R1 reset beats valid", 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule